// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the general-purpose registers of a 32-bit processor that runs in several operating modes. Software always sees sixteen architectural registers, numbered 0 to 15. Which physical word an index reaches depends on the current mode. The fast-interrupt mode has its own copies of indices 8 to 14. Four other privileged modes (IRQ, supervisor, abort and undefined) have only private stack-pointer and link registers at indices 13 and 14. User mode, and every code the block does not recognise, uses the shared words.

There are two read ports and one write port, each addressed by an index together with the current mode. Index 15 is not stored in the file. A read of index 15 returns the program-counter input aligned to a word. A write of index 15 is passed out as a branch target with a valid strobe. A separate link port writes index 14 of a chosen mode's bank. The core uses it to record the return address on a branch-with-link (current mode) and on exception entry (the mode being entered). Read data and the branch outputs are registered, so they appear one clock after the request.

Top module: `bank_regfile`

## Requirements
- R1: A word written through the write port to an index from 0 to 14 is returned on a read of the same index in the same mode issued on any later cycle.
- R2: A read of index 15 returns, one cycle later, the program-counter input sampled at the read's clock edge, with bits 1:0 forced to zero.
- R3: In fast-interrupt mode (code 5'b10001), indices 8 to 14 reach seven private words. Indices 0 to 7 in that mode reach the shared words.
- R4: IRQ (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) modes each have private words for indices 13 and 14. All their other indices reach the shared words that user mode (5'b10000) also uses.
- R5: Any mode code other than the six listed in R3 and R4 selects the user-mode mapping.
- R6: When link_en is high, link_data is written into index 14 of the bank selected by link_mode. This does not depend on mode_i.
- R7: When the link port and the write port target the same physical word in one cycle, the value from the link port is stored.
- R8: Read data appears one cycle after the index is presented. A read and a write of the same physical word in the same cycle return the value held before the write.
- R9: A write to index 15 changes no stored word. On the next cycle br_valid is high for one cycle and br_target carries the written data. br_target holds its value at other times.
- R10: A synchronous active-high reset clears every stored word, both read outputs, br_valid and br_target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 5 | Current operating mode code |
| rd_a_idx | input | 4 | Read port A architectural index |
| rd_a_data | output | 32 | Read port A data, registered |
| rd_b_idx | input | 4 | Read port B architectural index |
| rd_b_data | output | 32 | Read port B data, registered |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port architectural index |
| wr_data | input | 32 | Write port data |
| pc_i | input | 32 | Program counter value returned for index 15 |
| link_en | input | 1 | Link port enable |
| link_mode | input | 5 | Mode whose index 14 the link port writes |
| link_data | input | 32 | Return address written by the link port |
| br_valid | output | 1 | One-cycle strobe for a write to index 15 |
| br_target | output | 32 | Data of the most recent write to index 15 |

## Verification
The read-back property assumes that indices 0 to 7 are shared by every mode. It also assumes that no other write reaches the same index on the cycle between the write and the read. The bench does not rely on this assumption, because its reference model tracks every bank. The branch and reset properties need only one clean cycle after reset, so the bench holds reset for at least two clocks. Mode codes are mostly drawn from the six valid encodings, with some unlisted codes mixed in, so the checks cover the fallback mapping as well as the banked mappings.

// File: rtl/bank_regfile_pkg.sv
package bank_regfile_pkg;
  localparam int IDX_W    = 4;
  localparam int MODE_W   = 5;
  localparam int PC_IDX   = 15;
  localparam int LINK_IDX = 14;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011
  } mode_e;

  // physical layout: shared words, then fast bank, then pair banks
  localparam int SHARED_N  = 15;
  localparam int FIQ_LO    = 8;
  localparam int FIQ_N     = LINK_IDX - FIQ_LO + 1;
  localparam int PAIR_LO   = 13;
  localparam int PAIR_N    = LINK_IDX - PAIR_LO + 1;
  localparam int PRIV_N    = 4;
  localparam int FIQ_BASE  = SHARED_N;
  localparam int PAIR_BASE = FIQ_BASE + FIQ_N;
  localparam int PHYS_N    = PAIR_BASE + PAIR_N * PRIV_N;
  localparam int PHYS_W    = $clog2(PHYS_N);
endpackage

// File: rtl/bank_map.sv
module bank_map
  import bank_regfile_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [IDX_W-1:0]  idx,
  output logic [PHYS_W-1:0] phys
);
  logic       pair_hit;
  logic [1:0] pair_sel;

  always_comb begin
    pair_hit = 1'b1;
    pair_sel = 2'd0;
    case (mode)
      MODE_IRQ: pair_sel = 2'd0;
      MODE_SVC: pair_sel = 2'd1;
      MODE_ABT: pair_sel = 2'd2;
      MODE_UND: pair_sel = 2'd3;
      default:  pair_hit = 1'b0;
    endcase
  end

  always_comb begin
    phys = PHYS_W'(idx);
    if (int'(idx) >= FIQ_LO && int'(idx) <= LINK_IDX && mode == MODE_FIQ)
      phys = PHYS_W'(FIQ_BASE + int'(idx) - FIQ_LO);
    else if (int'(idx) >= PAIR_LO && int'(idx) <= LINK_IDX && pair_hit)
      phys = PHYS_W'(PAIR_BASE + PAIR_N * int'(pair_sel) + int'(idx) - PAIR_LO);
  end
endmodule

// File: rtl/bank_store.sv
module bank_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 30,
  parameter int RD_N   = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wa_en,
  input  logic [AW-1:0]                 wa_addr,
  input  logic [DATA_W-1:0]             wa_data,
  input  logic                          wb_en,
  input  logic [AW-1:0]                 wb_addr,
  input  logic [DATA_W-1:0]             wb_data,
  input  logic [RD_N-1:0][AW-1:0]       rd_addr,
  output logic [RD_N-1:0][DATA_W-1:0]   rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  // port b is applied last, so it wins on a shared address
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (wa_en) mem[wa_addr] <= wa_data;
      if (wb_en) mem[wb_addr] <= wb_data;
    end
  end

  for (genvar g = 0; g < RD_N; g++) begin : g_rd
    assign rd_data[g] = mem[rd_addr[g]];
  end
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_regfile_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        mode_i,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] pc_i,
  input  logic              link_en,
  input  logic [4:0]        link_mode,
  input  logic [DATA_W-1:0] link_data,
  output logic              br_valid,
  output logic [DATA_W-1:0] br_target
);
  localparam int MAP_N = 4;  // read a, read b, write, link
  localparam int RD_N  = 2;
  localparam logic [IDX_W-1:0] PC_I = IDX_W'(PC_IDX);

  logic [MAP_N-1:0][MODE_W-1:0] map_mode;
  logic [MAP_N-1:0][IDX_W-1:0]  map_idx;
  logic [MAP_N-1:0][PHYS_W-1:0] map_phys;

  assign map_mode = {link_mode, mode_i, mode_i, mode_i};
  assign map_idx  = {IDX_W'(LINK_IDX), wr_idx, rd_b_idx, rd_a_idx};

  for (genvar g = 0; g < MAP_N; g++) begin : g_map
    bank_map u_map (
      .mode (map_mode[g]),
      .idx  (map_idx[g]),
      .phys (map_phys[g])
    );
  end

  logic [RD_N-1:0][DATA_W-1:0] store_rd;
  logic                        wr_pc;
  logic [DATA_W-1:0]           pc_word;

  assign wr_pc   = wr_en && (wr_idx == PC_I);
  assign pc_word = pc_i & ~DATA_W'(3);

  bank_store #(
    .DATA_W (DATA_W),
    .DEPTH  (PHYS_N),
    .RD_N   (RD_N)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .wa_en   (wr_en && !wr_pc),
    .wa_addr (map_phys[2]),
    .wa_data (wr_data),
    .wb_en   (link_en),
    .wb_addr (map_phys[3]),
    .wb_data (link_data),
    .rd_addr ({map_phys[1], map_phys[0]}),
    .rd_data (store_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_a_data <= '0;
      rd_b_data <= '0;
    end else begin
      rd_a_data <= (rd_a_idx == PC_I) ? pc_word : store_rd[0];
      rd_b_data <= (rd_b_idx == PC_I) ? pc_word : store_rd[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      br_valid  <= 1'b0;
      br_target <= '0;
    end else begin
      br_valid <= wr_pc;
      if (wr_pc) br_target <= wr_data;
    end
  end
endmodule

// File: rtl/bank_regfile_chk.sv
module bank_regfile_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [3:0]        rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] pc_i,
  input logic              br_valid,
  input logic [DATA_W-1:0] br_target
);
  assert_pc_read_a_R2: assert property (@(posedge clk) disable iff (rst)
    rd_a_idx == 4'd15 |=> rd_a_data == ($past(pc_i) & ~DATA_W'(3)));

  assert_pc_read_b_R2: assert property (@(posedge clk) disable iff (rst)
    rd_b_idx == 4'd15 |=> rd_b_data == ($past(pc_i) & ~DATA_W'(3)));

  assert_branch_fwd_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_idx == 4'd15 |=> br_valid && br_target == $past(wr_data));

  assert_branch_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_idx == 4'd15) |=> !br_valid && $stable(br_target));

  assert_read_back_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx < 4'd8) ##1 (rd_a_idx == $past(wr_idx) && !(wr_en && wr_idx == rd_a_idx))
    |=> rd_a_data == $past(wr_data, 2));

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> rd_a_data == '0 && rd_b_data == '0 && !br_valid && br_target == '0);
endmodule

bind bank_regfile bank_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_a_idx  (rd_a_idx),
  .rd_a_data (rd_a_data),
  .rd_b_idx  (rd_b_idx),
  .rd_b_data (rd_b_data),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .pc_i      (pc_i),
  .br_valid  (br_valid),
  .br_target (br_target)
);

// File: tb/bank_regfile_test.sv
module bank_regfile_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  mode_i = 5'b10000;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, pc_i = '0, link_data = '0, br_target;
  logic        wr_en = 1'b0, link_en = 1'b0, br_valid;
  logic [4:0]  link_mode = 5'b10000;

  int checks = 0;
  int fails  = 0;

  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011;

  bank_regfile uut (
    .clk(clk), .rst(rst), .mode_i(mode_i),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .pc_i(pc_i),
    .link_en(link_en), .link_mode(link_mode), .link_data(link_data),
    .br_valid(br_valid), .br_target(br_target)
  );

  always #5 clk = ~clk;

  // reference model: words keyed by bank and index
  logic [31:0] model [int];
  logic [31:0] hold_bt = '0;

  function automatic int bank_key(logic [4:0] md, logic [3:0] ix);
    int k = int'(ix);
    case (md)
      FIQ:                if (ix >= 4'd8)  k = 1000 + int'(ix);
      IRQ, SVC, ABT, UND: if (ix >= 4'd13) k = int'(md) * 100 + int'(ix);
      default: ;
    endcase
    return k;
  endfunction

  function automatic logic [31:0] model_rd(logic [4:0] md, logic [3:0] ix);
    int k;
    if (ix == 4'd15) return {pc_i[31:2], 2'b00};
    k = bank_key(md, ix);
    return model.exists(k) ? model[k] : 32'h0;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic [31:0] ea, eb, ebt;
    logic        ebv;
    ea = model_rd(mode_i, rd_a_idx);
    eb = model_rd(mode_i, rd_b_idx);
    ebv = 1'b0;
    ebt = hold_bt;
    if (rst) begin
      model.delete();
      ea = '0; eb = '0; ebt = '0;
    end else begin
      if (wr_en) begin
        if (wr_idx == 4'd15) begin ebv = 1'b1; ebt = wr_data; end
        else model[bank_key(mode_i, wr_idx)] = wr_data;
      end
      if (link_en) model[bank_key(link_mode, 4'd14)] = link_data;
    end
    hold_bt = ebt;
    @(posedge clk); #1;
    check(tag, "rd_a_data", rd_a_data, ea);
    check(tag, "rd_b_data", rd_b_data, eb);
    check(tag, "br_valid", {31'b0, br_valid}, {31'b0, ebv});
    check(tag, "br_target", br_target, ebt);
  endtask

  task automatic quiet();
    wr_en = 1'b0; link_en = 1'b0;
  endtask

  task automatic wr(logic [4:0] md, logic [3:0] ix, logic [31:0] d, string tag);
    quiet(); mode_i = md; wr_en = 1'b1; wr_idx = ix; wr_data = d;
    step(tag);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] md, logic [3:0] ia, logic [3:0] ib, string tag);
    quiet(); mode_i = md; rd_a_idx = ia; rd_b_idx = ib;
    step(tag);
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [4:0] modes [8];
    modes = '{USR, FIQ, IRQ, SVC, ABT, UND, 5'b00000, 5'b10110};
    #1;
    rst = 1'b1; step("R10"); step("R10");
    rst = 1'b0;

    // R1 basic write and read back
    wr(USR, 4'd3, 32'hA5A5_0003, "R1");
    rd(USR, 4'd3, 4'd3, "R1");
    // R8 same-cycle read returns old value, then new one
    quiet(); mode_i = USR; rd_a_idx = 4'd5; wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'h0000_5555;
    step("R8");
    rd(USR, 4'd5, 4'd0, "R8");
    // R2 program counter read with low bits cleared
    pc_i = 32'h1234_5677; rd(SVC, 4'd15, 4'd15, "R2");
    pc_i = 32'hFFFF_FFFE; rd(FIQ, 4'd15, 4'd2, "R2");
    // R3 fast bank private for 8..14, shared below
    wr(USR, 4'd9, 32'h0000_0009, "R3");
    wr(FIQ, 4'd9, 32'hF1F1_0009, "R3");
    wr(USR, 4'd7, 32'h0000_0007, "R3");
    rd(FIQ, 4'd9, 4'd7, "R3");
    rd(USR, 4'd9, 4'd7, "R3");
    // R4 pair banks private for 13 and 14 only
    wr(IRQ, 4'd13, 32'h1111_000D, "R4");
    wr(SVC, 4'd13, 32'h2222_000D, "R4");
    wr(IRQ, 4'd12, 32'h1111_000C, "R4");
    rd(SVC, 4'd13, 4'd12, "R4");
    rd(IRQ, 4'd13, 4'd12, "R4");
    rd(USR, 4'd13, 4'd12, "R4");
    // R5 unlisted codes fall back to the user bank
    wr(USR, 4'd13, 32'hCAFE_000D, "R5");
    rd(5'b00000, 4'd13, 4'd9, "R5");
    rd(5'b11111, 4'd14, 4'd13, "R5");
    // R6 link port writes the chosen mode's index 14
    quiet(); mode_i = USR; link_en = 1'b1; link_mode = ABT; link_data = 32'hABAB_000E;
    step("R6");
    rd(ABT, 4'd14, 4'd14, "R6");
    rd(USR, 4'd14, 4'd14, "R6");
    // R7 link beats the write port on the same word
    quiet(); mode_i = UND; wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'h0BAD_0BAD;
    link_en = 1'b1; link_mode = UND; link_data = 32'h600D_600D;
    step("R7");
    rd(UND, 4'd14, 4'd13, "R7");
    // R9 write to index 15 goes to branch outputs only
    pc_i = 32'h0000_8000;
    wr(USR, 4'd15, 32'h0000_4444, "R9");
    rd(USR, 4'd15, 4'd3, "R9");
    rd(USR, 4'd0, 4'd1, "R9");

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      mode_i    = modes[$urandom_range(0, 7)];
      rd_a_idx  = 4'($urandom);
      rd_b_idx  = 4'($urandom);
      wr_en     = ($urandom_range(0, 3) != 0);
      wr_idx    = 4'($urandom);
      wr_data   = $urandom;
      pc_i      = $urandom;
      link_en   = ($urandom_range(0, 3) == 0);
      link_mode = modes[$urandom_range(0, 7)];
      link_data = $urandom;
      step("R8");
    end

    // R10 reset in mid-run clears stored words
    quiet(); rst = 1'b1; step("R10"); step("R10"); rst = 1'b0;
    rd(FIQ, 4'd9, 4'd3, "R10");
    rd(IRQ, 4'd13, 4'd14, "R10");

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule